// File: doc/BRIEF.md
# Cartridge Bank Controller

This block sits between a CPU's 16-bit address bus and a cartridge that holds a large ROM, a banked external RAM and a small set of clock registers. The ROM address space is read-only, so the CPU's writes into it are decoded as control register writes. One register picks the upper ROM bank. One key register opens or closes the external window. One select register points the window at a RAM bank or at a clock register. One latch-control register produces a latch strobe.

Reads in the lower 16 KiB always come from ROM bank 0. Reads in the upper 16 KiB come from the selected 7-bit bank. Accesses in the 8 KiB window at 0xA000 go to RAM or to the clock-register port, depending on the select register. The block only translates addresses and gates strobes. It drives the absolute ROM and RAM addresses, the RAM and clock-register write enables, the clock-register index, the latch strobe, and a source code that tells the surrounding read-data mux where the byte comes from. The clock counting itself is left to the clock-register port.

Top module: `cart_bank_ctl`

## Requirements
- R1: While rst_ni is low, and after it is released, the ROM bank, window select and latch history are all 0 and the window is disabled. In that state, a read at 0xA000 reports source OPEN (3) and a read at 0x4000 gives ROM address 0.
- R2: An access in 0x0000–0x3FFF reports source ROM (0), with rom_addr_o equal to the address itself.
- R3: An access in 0x4000–0x7FFF reports source ROM (0), with rom_addr_o = bank × 0x4000 + (address − 0x4000).
- R4: A write in 0x2000–0x3FFF loads the ROM bank with data AND 0x7F. The new bank applies from the following cycle.
- R5: A write in 0x0000–0x1FFF with data 0x0A enables the window and data 0x00 disables it. Any other data leaves the enable unchanged.
- R6: A write in 0x4000–0x5FFF with data 0x00–0x03 selects that RAM bank. Data 0x08–0x0C selects clock register (data − 8). Any other value leaves the select unchanged.
- R7: With the window enabled and a RAM bank selected, an access in 0xA000–0xBFFF reports source RAM (1), with ram_addr_o = bank × 0x2000 + (address − 0xA000). ram_we_o is high in the cycle of a write.
- R8: With the window enabled and a clock register selected, an access in 0xA000–0xBFFF reports source CLK (2) and gives the register index on clk_sel_o. clk_we_o is high on a write and ram_we_o stays low.
- R9: With the window disabled, an access in 0xA000–0xBFFF reports source OPEN (3), and both ram_we_o and clk_we_o stay low.
- R10: latch_o pulses high for exactly the one cycle after a write of 0x01 in 0x6000–0x7FFF, but only when the last accepted latch write before it was 0x00. Values other than 0x00 and 0x01 are ignored.
- R11: An access at 0x8000–0x9FFF or 0xC000–0xFFFF reports source OPEN (3), raises no write enable, and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe, one cycle per write |
| rom_addr_o | output | 21 | Absolute ROM byte address |
| ram_addr_o | output | 15 | Absolute RAM byte address |
| ram_we_o | output | 1 | RAM write enable |
| clk_sel_o | output | 3 | Clock register index, 0 to 4 |
| clk_we_o | output | 1 | Clock register write enable |
| latch_o | output | 1 | One-cycle clock latch strobe |
| rd_src_o | output | 2 | Read source: 0 ROM, 1 RAM, 2 CLK, 3 OPEN |

## Verification
Every piece of control state shows up combinationally at the ports in the first cycle after the write that changed it:
- A wrong ROM bank is visible at once in the upper bits of rom_addr_o on the next upper-bank read.
- A corrupt select register appears as a wrong source code, RAM bank bits or clock index on the next window access.
- A stuck enable shows as a write enable that fires, or fails to fire, on a window write.
- A lost or stale latch history is visible only through latch_o in the single cycle after a 0x01 write.

The stimulus therefore reads back through the window immediately after each control write. It also includes rejected values, to prove that they leave the visible state untouched.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam int CPU_AW     = 16;
  localparam int DW         = 8;
  localparam int ROM_BANK_W = 7;
  localparam int ROM_OFS_W  = 14;
  localparam int RAM_BANKS  = 4;
  localparam int RAM_OFS_W  = 13;
  localparam int CLK_REGS   = 5;
  localparam int CLK_BASE   = 8;

  localparam int RAM_BANK_W = $clog2(RAM_BANKS);
  localparam int CLK_SEL_W  = $clog2(CLK_REGS);
  localparam int IDX_W      = (RAM_BANK_W > CLK_SEL_W) ? RAM_BANK_W : CLK_SEL_W;
  localparam int ROM_AW     = ROM_BANK_W + ROM_OFS_W;
  localparam int RAM_AW     = RAM_BANK_W + RAM_OFS_W;

  localparam logic [DW-1:0] EN_KEY    = 8'h0A;
  localparam logic [DW-1:0] DIS_KEY   = 8'h00;
  localparam logic [DW-1:0] LATCH_LO  = 8'h00;
  localparam logic [DW-1:0] LATCH_HI  = 8'h01;

  typedef enum logic [1:0] {
    SRC_ROM  = 2'd0,
    SRC_RAM  = 2'd1,
    SRC_CLK  = 2'd2,
    SRC_OPEN = 2'd3
  } rd_src_e;

  typedef enum logic [2:0] {
    HIT_NONE,
    HIT_ENABLE,
    HIT_ROM_BANK,
    HIT_WIN_SEL,
    HIT_LATCH
  } reg_hit_e;

  typedef struct packed {
    logic rom_lo;
    logic rom_hi;
    logic win;
  } region_t;
endpackage

// File: rtl/cart_bank_decode.sv
module cart_bank_decode
  import cart_bank_pkg::*;
(
  input  logic [CPU_AW-1:0] addr_i,
  output region_t           region_o,
  output reg_hit_e          hit_o
);
  // 16 KiB halves of the ROM space, 8 KiB window at 0xA000
  always_comb begin
    region_o.rom_lo = (addr_i[15:14] == 2'b00);
    region_o.rom_hi = (addr_i[15:14] == 2'b01);
    region_o.win    = (addr_i[15:13] == 3'b101);
  end

  always_comb begin
    hit_o = HIT_NONE;
    if (!addr_i[15]) begin
      unique case (addr_i[14:13])
        2'b00:   hit_o = HIT_ENABLE;
        2'b01:   hit_o = HIT_ROM_BANK;
        2'b10:   hit_o = HIT_WIN_SEL;
        default: hit_o = HIT_LATCH;
      endcase
    end
  end
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_bank_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  reg_hit_e              hit_i,
  input  logic [DW-1:0]         wdata_i,
  output logic                  win_en_o,
  output logic [ROM_BANK_W-1:0] rom_bank_o,
  output logic                  win_clk_o,
  output logic [IDX_W-1:0]      win_idx_o,
  output logic                  latch_o
);
  logic                  win_en_q;
  logic [ROM_BANK_W-1:0] rom_bank_q;
  logic                  win_clk_q;
  logic [IDX_W-1:0]      win_idx_q;
  logic                  latch_arm_q;
  logic                  latch_q;

  logic sel_is_ram, sel_is_clk;
  logic [DW-1:0] clk_rel;

  always_comb begin
    clk_rel    = wdata_i - DW'(CLK_BASE);
    sel_is_ram = (wdata_i < DW'(RAM_BANKS));
    sel_is_clk = (wdata_i >= DW'(CLK_BASE)) && (clk_rel < DW'(CLK_REGS));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_en_q    <= 1'b0;
      rom_bank_q  <= '0;
      win_clk_q   <= 1'b0;
      win_idx_q   <= '0;
      latch_arm_q <= 1'b0;
      latch_q     <= 1'b0;
    end else begin
      latch_q <= 1'b0;
      if (we_i) begin
        unique case (hit_i)
          HIT_ENABLE: begin
            if (wdata_i == EN_KEY)       win_en_q <= 1'b1;
            else if (wdata_i == DIS_KEY) win_en_q <= 1'b0;
          end
          HIT_ROM_BANK: rom_bank_q <= wdata_i[ROM_BANK_W-1:0];
          HIT_WIN_SEL: begin
            if (sel_is_ram) begin
              win_clk_q <= 1'b0;
              win_idx_q <= IDX_W'(wdata_i);
            end else if (sel_is_clk) begin
              win_clk_q <= 1'b1;
              win_idx_q <= IDX_W'(clk_rel);
            end
          end
          HIT_LATCH: begin
            if (wdata_i == LATCH_LO) begin
              latch_arm_q <= 1'b1;
            end else if (wdata_i == LATCH_HI) begin
              latch_arm_q <= 1'b0;
              latch_q     <= latch_arm_q;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign win_en_o   = win_en_q;
  assign rom_bank_o = rom_bank_q;
  assign win_clk_o  = win_clk_q;
  assign win_idx_o  = win_idx_q;
  assign latch_o    = latch_q;

  // R6: select always holds a legal RAM bank or clock register
  a_r6_sel_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_clk_q ? (win_idx_q < IDX_W'(CLK_REGS)) : (win_idx_q < IDX_W'(RAM_BANKS)));

  a_r4_bank_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_i == HIT_ROM_BANK) |=> (rom_bank_q == $past(wdata_i[ROM_BANK_W-1:0])));

  a_r5_en_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_i == HIT_ENABLE && wdata_i != EN_KEY && wdata_i != DIS_KEY)
      |=> $stable(win_en_q));

  a_r10_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_q |=> !latch_q);

  a_r11_no_reg_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i == HIT_NONE) |=> ($stable(win_en_q) && $stable(rom_bank_q) &&
                             $stable(win_idx_q) && $stable(win_clk_q)));
endmodule

// File: rtl/cart_bank_map.sv
module cart_bank_map
  import cart_bank_pkg::*;
(
  input  logic [CPU_AW-1:0]     addr_i,
  input  logic                  we_i,
  input  region_t               region_i,
  input  logic                  win_en_i,
  input  logic [ROM_BANK_W-1:0] rom_bank_i,
  input  logic                  win_clk_i,
  input  logic [IDX_W-1:0]      win_idx_i,
  output logic [ROM_AW-1:0]     rom_addr_o,
  output logic [RAM_AW-1:0]     ram_addr_o,
  output logic                  ram_we_o,
  output logic [CLK_SEL_W-1:0]  clk_sel_o,
  output logic                  clk_we_o,
  output rd_src_e               rd_src_o
);
  logic [ROM_BANK_W-1:0] eff_bank;
  logic                  win_live;

  assign eff_bank   = region_i.rom_hi ? rom_bank_i : '0;
  assign rom_addr_o = {eff_bank, addr_i[ROM_OFS_W-1:0]};
  assign ram_addr_o = {win_idx_i[RAM_BANK_W-1:0], addr_i[RAM_OFS_W-1:0]};
  assign clk_sel_o  = win_idx_i[CLK_SEL_W-1:0];
  assign win_live   = region_i.win && win_en_i;
  assign ram_we_o   = we_i && win_live && !win_clk_i;
  assign clk_we_o   = we_i && win_live && win_clk_i;

  always_comb begin
    if (region_i.rom_lo || region_i.rom_hi) rd_src_o = SRC_ROM;
    else if (!win_live)                     rd_src_o = SRC_OPEN;
    else if (win_clk_i)                     rd_src_o = SRC_CLK;
    else                                    rd_src_o = SRC_RAM;
  end
endmodule

// File: rtl/cart_bank_ctl.sv
module cart_bank_ctl
  import cart_bank_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CPU_AW-1:0]    cpu_addr_i,
  input  logic [DW-1:0]        cpu_wdata_i,
  input  logic                 cpu_we_i,
  output logic [ROM_AW-1:0]    rom_addr_o,
  output logic [RAM_AW-1:0]    ram_addr_o,
  output logic                 ram_we_o,
  output logic [CLK_SEL_W-1:0] clk_sel_o,
  output logic                 clk_we_o,
  output logic                 latch_o,
  output logic [1:0]           rd_src_o
);
  region_t               region;
  reg_hit_e              hit;
  logic                  win_en;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic                  win_clk;
  logic [IDX_W-1:0]      win_idx;
  rd_src_e               rd_src;

  cart_bank_decode u_decode (
    .addr_i   (cpu_addr_i),
    .region_o (region),
    .hit_o    (hit)
  );

  cart_bank_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cpu_we_i),
    .hit_i      (hit),
    .wdata_i    (cpu_wdata_i),
    .win_en_o   (win_en),
    .rom_bank_o (rom_bank),
    .win_clk_o  (win_clk),
    .win_idx_o  (win_idx),
    .latch_o    (latch_o)
  );

  cart_bank_map u_map (
    .addr_i     (cpu_addr_i),
    .we_i       (cpu_we_i),
    .region_i   (region),
    .win_en_i   (win_en),
    .rom_bank_i (rom_bank),
    .win_clk_i  (win_clk),
    .win_idx_i  (win_idx),
    .rom_addr_o (rom_addr_o),
    .ram_addr_o (ram_addr_o),
    .ram_we_o   (ram_we_o),
    .clk_sel_o  (clk_sel_o),
    .clk_we_o   (clk_we_o),
    .rd_src_o   (rd_src)
  );

  assign rd_src_o = rd_src;

  a_r7_we_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && clk_we_o));

  a_r9_closed_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_src == SRC_OPEN) |-> (!ram_we_o && !clk_we_o));

  a_r8_clk_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_we_o |-> (rd_src == SRC_CLK));

  a_r11_high_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[15] && cpu_addr_i[14:13] != 2'b01) |-> (rd_src == SRC_OPEN));
endmodule

// File: tb/cart_bank_ctl_tb.sv
module cart_bank_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic        ram_we, clk_we, latch;
  logic [2:0]  clk_sel;
  logic [1:0]  rd_src;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  cart_bank_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
    .cpu_we_i(we), .rom_addr_o(rom_addr), .ram_addr_o(ram_addr),
    .ram_we_o(ram_we), .clk_sel_o(clk_sel), .clk_we_o(clk_we),
    .latch_o(latch), .rd_src_o(rd_src)
  );

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [1:0]  src;
    logic [20:0] rom;
    logic [14:0] ram;
    logic        rwe;
    logic        cwe;
    logic [2:0]  csel;
    logic        lat;
    logic [3:0]  req;
  } vec_t;

  // src: 0 ROM, 1 RAM, 2 CLK, 3 OPEN
  localparam int NV = 44;
  localparam vec_t TBL [NV] = '{
    {1'b0,16'h0123,8'h00,2'd0,21'h000123,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd2},   // R2
    {1'b0,16'h3FFF,8'h00,2'd0,21'h003FFF,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd2},   // R2
    {1'b0,16'h4000,8'h00,2'd0,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd1},   // R1
    {1'b0,16'hA000,8'h00,2'd3,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd1},   // R1
    {1'b1,16'hA010,8'h55,2'd3,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd9},   // R9
    {1'b1,16'h2000,8'h85,2'd0,21'h002000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd4},   // R4
    {1'b0,16'h4001,8'h00,2'd0,21'h014001,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd4},   // R4
    {1'b0,16'h7FFF,8'h00,2'd0,21'h017FFF,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd3},   // R3
    {1'b1,16'h3FFF,8'h7F,2'd0,21'h003FFF,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd4},   // R4
    {1'b0,16'h6000,8'h00,2'd0,21'h1FE000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd3},   // R3
    {1'b1,16'h1000,8'h0A,2'd0,21'h001000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd5},   // R5
    {1'b1,16'h4000,8'h02,2'd0,21'h1FC000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd6},   // R6
    {1'b0,16'hB234,8'h00,2'd1,21'h000000,15'h5234,1'b0,1'b0,3'd0,1'b0,4'd7},   // R7
    {1'b1,16'hBFFF,8'h11,2'd1,21'h000000,15'h5FFF,1'b1,1'b0,3'd0,1'b0,4'd7},   // R7
    {1'b1,16'h4000,8'h05,2'd0,21'h1FC000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd6},   // R6
    {1'b0,16'hA000,8'h00,2'd1,21'h000000,15'h4000,1'b0,1'b0,3'd0,1'b0,4'd6},   // R6
    {1'b1,16'h5FFF,8'h0C,2'd0,21'h1FDFFF,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd6},   // R6
    {1'b1,16'hA003,8'h99,2'd2,21'h000000,15'h0000,1'b0,1'b1,3'd4,1'b0,4'd8},   // R8
    {1'b1,16'h4000,8'h08,2'd0,21'h1FC000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd6},   // R6
    {1'b0,16'hBFFF,8'h00,2'd2,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd8},   // R8
    {1'b1,16'h0000,8'h33,2'd0,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd5},   // R5
    {1'b0,16'hA000,8'h00,2'd2,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd5},   // R5
    {1'b1,16'h4000,8'h0D,2'd0,21'h1FC000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd6},   // R6
    {1'b0,16'hA000,8'h00,2'd2,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd6},   // R6
    {1'b1,16'h4000,8'h03,2'd0,21'h1FC000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd6},   // R6
    {1'b1,16'h1FFF,8'h00,2'd0,21'h001FFF,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd5},   // R5
    {1'b1,16'hA000,8'h12,2'd3,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd9},   // R9
    {1'b1,16'h8000,8'h01,2'd3,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd11},  // R11
    {1'b1,16'hC000,8'h0A,2'd3,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd11},  // R11
    {1'b0,16'hA000,8'h00,2'd3,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd11},  // R11
    {1'b1,16'h6000,8'h01,2'd0,21'h1FE000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd10},  // R10
    {1'b0,16'h0000,8'h00,2'd0,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd10},  // R10 no arm
    {1'b1,16'h6000,8'h00,2'd0,21'h1FE000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd10},  // R10
    {1'b1,16'h7FFF,8'h01,2'd0,21'h1FFFFF,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd10},  // R10
    {1'b0,16'h0000,8'h00,2'd0,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b1,4'd10},  // R10 pulse
    {1'b0,16'h0000,8'h00,2'd0,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd10},  // R10 one cycle
    {1'b1,16'h6000,8'h01,2'd0,21'h1FE000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd10},  // R10
    {1'b0,16'h0000,8'h00,2'd0,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd10},  // R10 disarmed
    {1'b1,16'h6000,8'h00,2'd0,21'h1FE000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd10},  // R10
    {1'b1,16'h6000,8'h02,2'd0,21'h1FE000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd10},  // R10 ignored
    {1'b1,16'h6000,8'h01,2'd0,21'h1FE000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd10},  // R10
    {1'b0,16'h0000,8'h00,2'd0,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b1,4'd10},  // R10 pulse
    {1'b1,16'h0000,8'h0A,2'd0,21'h000000,15'h0000,1'b0,1'b0,3'd0,1'b0,4'd5},   // R5
    {1'b1,16'hA001,8'h05,2'd1,21'h000000,15'h6001,1'b1,1'b0,3'd0,1'b0,4'd7}    // R7
  };

  task automatic check(input int req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic drive(input logic w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    we = w; addr = a; wdata = d;
    #1;
  endtask

  initial begin
    // R1: state while reset is held
    #1;
    addr = 16'hA000;
    #1;
    check(1, "src in reset", int'(rd_src), 3);
    check(1, "latch in reset", int'(latch), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].we, TBL[i].addr, TBL[i].wd);
      check(int'(TBL[i].req), $sformatf("row %0d src", i), int'(rd_src), int'(TBL[i].src));
      if (TBL[i].src == 2'd0)
        check(int'(TBL[i].req), $sformatf("row %0d rom", i), int'(rom_addr), int'(TBL[i].rom));
      if (TBL[i].src == 2'd1)
        check(int'(TBL[i].req), $sformatf("row %0d ram", i), int'(ram_addr), int'(TBL[i].ram));
      if (TBL[i].src == 2'd2)
        check(int'(TBL[i].req), $sformatf("row %0d csel", i), int'(clk_sel), int'(TBL[i].csel));
      check(int'(TBL[i].req), $sformatf("row %0d ram_we", i), int'(ram_we), int'(TBL[i].rwe));
      check(int'(TBL[i].req), $sformatf("row %0d clk_we", i), int'(clk_we), int'(TBL[i].cwe));
      check(int'(TBL[i].req), $sformatf("row %0d latch", i), int'(latch), int'(TBL[i].lat));
    end

    // R1: mid-run reset clears bank, select and enable
    drive(1'b1, 16'h2000, 8'h03);
    drive(1'b1, 16'h4000, 8'h09);
    drive(1'b0, 16'h4000, 8'h00);
    check(4, "bank before reset", int'(rom_addr), 21'h00C000);
    #1 rst_n = 1'b0;
    #1;
    check(1, "bank in reset", int'(rom_addr), 0);
    drive(1'b0, 16'hA000, 8'h00);
    check(1, "src in reset", int'(rd_src), 3);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 16'h0000, 8'h0A);
    drive(1'b0, 16'hA123, 8'h00);
    check(1, "select after reset", int'(rd_src), 1);
    check(1, "ram bank after reset", int'(ram_addr), 15'h0123);
    // R10: latch history cleared by reset
    drive(1'b1, 16'h6000, 8'h01);
    drive(1'b0, 16'h0000, 8'h00);
    check(10, "latch after reset", int'(latch), 0);
    // R3: bank 0x7F masks bit 7 of 0xFF
    drive(1'b1, 16'h2ABC, 8'hFF);
    drive(1'b0, 16'h4ABC, 8'h00);
    check(3, "bank masked", int'(rom_addr), 21'h1FCABC);
    drive(1'b0, 16'h0000, 8'h00);
    finish_run();
  end
endmodule